// File: doc/BRIEF.md
# Two-Bank Page-Mode DRAM Sequencer

This block sits between a single granted bus master and a pair of DRAM banks. It accepts one word-sized read or write at a time and expands it into a timed command sequence: an optional row change, an optional bus turnaround, and a two-cycle column strobe. Each bank remembers the row it last opened and keeps it open afterwards. Later accesses to that row pay only the strobe time, and alternating between banks leaves both rows in place.

The master offers a request with `req_valid`, an address, a write flag and write data. The request is taken on a clock edge where `ready` is high. `ready` stays low while the sequence runs. A read returns its word with a one-cycle `rd_valid` pulse. Per-bank outputs show which row is open, when the column strobe fires and whether it writes. A free-running busy counter totals every cycle spent in a sequence, so software-style copy loops can be timed in cycles. Storage behind the banks is a behavioural array.

Top module: `dram2_seq`

## Requirements
- R1: After reset `ready` is high, `rd_valid` is low, no bank shows an open row or a strobe, and `busy_cnt` is zero.
- R2: The bank is the top address bit (bit 8 by default), the row the next ROW_W bits (bits 7:4), and the column the low COL_W bits (bits 3:0). Equal row and column in the two banks address separate words.
- R3: An access to the row already open in its bank, with no direction change, keeps `ready` low for exactly 2 cycles, and both cycles drive that bank's `col_stb`.
- R4: An access to a bank whose row is closed or different adds 3 cycles before the strobe. That bank's `row_act` is low for those 3 cycles and high from the next cycle on.
- R5: A write that follows a read adds 1 turnaround cycle just before its strobe. A read that follows a write adds none.
- R6: A request is taken only on an edge where `ready` is high. `ready` falls in the next cycle and stays low for the whole sequence. A request offered and withdrawn while `ready` is low has no effect.
- R7: A read raises `rd_valid` for exactly one cycle, the cycle after its last strobe cycle, with `rd_data` holding the last word written to that address.
- R8: A write stores its data at its address, and `wr_en` of the bank is high during both strobe cycles of the write and at no other time.
- R9: Each bank keeps its open row until an access to a different row of the same bank. Accesses to the other bank never close it.
- R10: `busy_cnt` rises by one for every cycle in which `ready` is low. A steady read-from-row-A, write-to-row-B copy in one bank costs 11 cycles per word. The same copy with source and destination rows held open in separate banks costs 5.
- R11: In no cycle do both banks strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_addr | input | AW (9) | Word address: bank, row, column |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (16) | Write data |
| ready | output | 1 | Sequencer idle; request is taken on this edge |
| rd_valid | output | 1 | One-cycle read-return pulse |
| rd_data | output | DW (16) | Read word, valid with `rd_valid` |
| row_act | output | NUM_BANKS (2) | Per bank: a row is open and not being changed |
| col_stb | output | NUM_BANKS (2) | Per bank: column strobe cycle |
| wr_en | output | NUM_BANKS (2) | Per bank: strobe cycle is a write |
| busy_cnt | output | CNT_W (16) | Running total of busy cycles |

## Verification
The hardest situation to reach is the steady state of the copy loops. The 11-cycle and 5-cycle costs only appear once the banks already hold particular rows and the last bus direction is known. The bench first writes the source rows so that they are open, runs one warm-up word, and only then measures the per-word cost from the counter. A request that is offered and then withdrawn while a row change is in progress is the other case that needs deliberate timing. The bench raises it mid-sequence and later reads the targeted word back to show that it is unchanged.

// File: rtl/dram2_pkg.sv
package dram2_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ROWCHG = 2'd1,
        PH_TURN   = 2'd2,
        PH_STROBE = 2'd3
    } phase_e;

    localparam int ROWCHG_CYCLES = 3;
    localparam int STROBE_CYCLES = 2;

endpackage

// File: rtl/dram2_bank_row.sv
module dram2_bank_row #(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row,
    output logic             row_open,
    output logic [ROW_W-1:0] row_q
);

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } rowst_t;

    rowst_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (open_en) begin
            s_d.valid = 1'b1;
            s_d.row   = open_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_open = s_q.valid;
    assign row_q    = s_q.row;

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open && !open_en) |=> (row_open && $stable(row_q))); // R9

endmodule

// File: rtl/dram2_bank_mem.sv
module dram2_bank_mem #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    localparam int IDX_W = ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0]    mem [DEPTH];
    logic [IDX_W-1:0] idx;

    assign idx   = {row, col};
    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

endmodule

// File: rtl/dram2_ctrl.sv
module dram2_ctrl
    import dram2_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DW        = 16,
    parameter int CNT_W     = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW       = BANK_W + ROW_W + COL_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [AW-1:0]                   req_addr,
    input  logic                            req_wr,
    input  logic [DW-1:0]                   req_wdata,
    input  logic [NUM_BANKS-1:0]            bank_open,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
    input  logic [DW-1:0]                   rd_word,
    output logic                            ready,
    output logic [NUM_BANKS-1:0]            open_en,
    output logic [ROW_W-1:0]                open_row,
    output logic [BANK_W-1:0]               cur_bank,
    output logic [ROW_W-1:0]                cur_row,
    output logic [COL_W-1:0]                cur_col,
    output logic [DW-1:0]                   cur_wdata,
    output logic                            wr_fire,
    output logic                            stb_any,
    output logic                            wr_any,
    output logic                            in_rowchg,
    output logic                            rd_valid,
    output logic [DW-1:0]                   rd_data,
    output logic [CNT_W-1:0]                busy_cnt
);

    localparam logic [1:0] ROW_LAST = 2'(ROWCHG_CYCLES - 1);
    localparam logic [1:0] STB_LAST = 2'(STROBE_CYCLES - 1);

    typedef struct packed {
        phase_e             phase;
        logic [1:0]         cnt;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic               is_wr;
        logic               need_turn;
        logic [DW-1:0]      wdata;
        logic               last_valid;
        logic               last_wr;
        logic               rd_valid;
        logic [DW-1:0]      rd_data;
        logic [CNT_W-1:0]   busy;
    } seq_t;

    seq_t s_q, s_d;

    logic [BANK_W-1:0] a_bank;
    logic [ROW_W-1:0]  a_row;
    logic [COL_W-1:0]  a_col;
    logic              a_hit;
    logic              a_turn;

    assign a_bank = req_addr[AW-1 -: BANK_W];
    assign a_row  = req_addr[COL_W +: ROW_W];
    assign a_col  = req_addr[COL_W-1:0];
    assign a_hit  = bank_open[a_bank] && (bank_row[a_bank] == a_row);
    // Only a read-to-write switch needs the shared data bus to turn around.
    assign a_turn = s_q.last_valid && !s_q.last_wr && req_wr;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        s_d.busy     = s_q.busy + CNT_W'(s_q.phase != PH_IDLE);
        open_en      = '0;
        wr_fire      = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.bank      = a_bank;
                    s_d.row       = a_row;
                    s_d.col       = a_col;
                    s_d.is_wr     = req_wr;
                    s_d.wdata     = req_wdata;
                    s_d.need_turn = a_turn;
                    if (!a_hit) begin
                        open_en[a_bank] = 1'b1;
                        s_d.phase       = PH_ROWCHG;
                        s_d.cnt         = ROW_LAST;
                    end else if (a_turn) begin
                        s_d.phase = PH_TURN;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.phase = PH_STROBE;
                        s_d.cnt   = STB_LAST;
                    end
                end
            end
            PH_ROWCHG: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 2'd1;
                end else if (s_q.need_turn) begin
                    s_d.phase = PH_TURN;
                end else begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = STB_LAST;
                end
            end
            PH_TURN: begin
                s_d.phase = PH_STROBE;
                s_d.cnt   = STB_LAST;
            end
            PH_STROBE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 2'd1;
                end else begin
                    s_d.phase      = PH_IDLE;
                    s_d.last_valid = 1'b1;
                    s_d.last_wr    = s_q.is_wr;
                    if (s_q.is_wr) begin
                        wr_fire = 1'b1;
                    end else begin
                        s_d.rd_valid = 1'b1;
                        s_d.rd_data  = rd_word;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready     = (s_q.phase == PH_IDLE);
    assign open_row  = a_row;
    assign cur_bank  = s_q.bank;
    assign cur_row   = s_q.row;
    assign cur_col   = s_q.col;
    assign cur_wdata = s_q.wdata;
    assign stb_any   = (s_q.phase == PH_STROBE);
    assign wr_any    = stb_any && s_q.is_wr;
    assign in_rowchg = (s_q.phase == PH_ROWCHG);
    assign rd_valid  = s_q.rd_valid;
    assign rd_data   = s_q.rd_data;
    assign busy_cnt  = s_q.busy;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready); // R6
    AST_STB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_any) |=> stb_any); // R3
    AST_STB_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_any && $past(stb_any)) |=> !stb_any); // R3
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R7
    AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(stb_any && !wr_any)); // R7
    AST_ROWCHG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rowchg && $past(in_rowchg) && $past(in_rowchg, 2)) |=> !in_rowchg); // R4
    AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != $past(busy_cnt)) |-> (busy_cnt == $past(busy_cnt) + CNT_W'(1))); // R10

endmodule

// File: rtl/dram2_seq.sv
module dram2_seq
    import dram2_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 4,
    parameter int DW        = 16,
    parameter int CNT_W     = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int AW       = BANK_W + ROW_W + COL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    input  logic                 req_wr,
    input  logic [DW-1:0]        req_wdata,
    output logic                 ready,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_BANKS-1:0] row_act,
    output logic [NUM_BANKS-1:0] col_stb,
    output logic [NUM_BANKS-1:0] wr_en,
    output logic [CNT_W-1:0]     busy_cnt
);

    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic [NUM_BANKS-1:0]            open_en;
    logic [ROW_W-1:0]                open_row;
    logic [BANK_W-1:0]               cur_bank;
    logic [ROW_W-1:0]                cur_row;
    logic [COL_W-1:0]                cur_col;
    logic [DW-1:0]                   cur_wdata;
    logic                            wr_fire;
    logic                            stb_any;
    logic                            wr_any;
    logic                            in_rowchg;
    logic [DW-1:0]                   bank_rd [NUM_BANKS];
    logic [DW-1:0]                   rd_word;

    dram2_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .DW        (DW),
        .CNT_W     (CNT_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .bank_open (bank_open),
        .bank_row  (bank_row),
        .rd_word   (rd_word),
        .ready     (ready),
        .open_en   (open_en),
        .open_row  (open_row),
        .cur_bank  (cur_bank),
        .cur_row   (cur_row),
        .cur_col   (cur_col),
        .cur_wdata (cur_wdata),
        .wr_fire   (wr_fire),
        .stb_any   (stb_any),
        .wr_any    (wr_any),
        .in_rowchg (in_rowchg),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .busy_cnt  (busy_cnt)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (cur_bank == BANK_W'(b));

        dram2_bank_row #(
            .ROW_W (ROW_W)
        ) i_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_en  (open_en[b]),
            .open_row (open_row),
            .row_open (bank_open[b]),
            .row_q    (bank_row[b])
        );

        dram2_bank_mem #(
            .ROW_W (ROW_W),
            .COL_W (COL_W),
            .DW    (DW)
        ) i_mem (
            .clk   (clk),
            .we    (wr_fire && sel),
            .row   (cur_row),
            .col   (cur_col),
            .wdata (cur_wdata),
            .rdata (bank_rd[b])
        );

        assign row_act[b] = bank_open[b] && !(in_rowchg && sel);
        assign col_stb[b] = stb_any && sel;
        assign wr_en[b]   = wr_any && sel;
    end

    assign rd_word = bank_rd[cur_bank];

    AST_ONE_BANK_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_stb)); // R11
    AST_WR_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> ((wr_en & row_act) == wr_en)); // R8

endmodule

// File: tb/test_dram2_seq.sv
module test_dram2_seq;

    localparam int AW = 9;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          req_wr;
    logic [DW-1:0] req_wdata;
    logic          ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [1:0]    row_act;
    logic [1:0]    col_stb;
    logic [1:0]    wr_en;
    logic [15:0]   busy_cnt;

    always #4 clk = ~clk;

    dram2_seq i_dram2_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .row_act   (row_act),
        .col_stb   (col_stb),
        .wr_en     (wr_en),
        .busy_cnt  (busy_cnt)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference: per-cycle queue of phases (0 row change, 1 turn, 2 strobe)
    int          q[$];
    int          m_bank, m_addr;
    bit          m_wr;
    int          m_wdata;
    bit          open_v[2];
    int          open_r[2];
    bit          last_valid, last_wr;
    int          exp_busy, exp_rd;
    bit          exp_rdv, accepted;
    int          mem[int];

    function automatic logic [AW-1:0] mk(int b, int r, int c);
        return AW'((b << 8) | (r << 4) | c);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        int front;
        front = (q.size() > 0) ? q[0] : -1;
        chk(ready == (q.size() == 0), "R6", "ready", ready, q.size() == 0);
        for (int b = 0; b < 2; b++) begin
            bit es, ew, ea;
            es = (front == 2) && (m_bank == b);
            ew = es && m_wr;
            ea = open_v[b] && !((front == 0) && (m_bank == b));
            chk(col_stb[b] == es, "R3", $sformatf("col_stb[%0d]", b), col_stb[b], es);
            chk(wr_en[b] == ew, "R8", $sformatf("wr_en[%0d]", b), wr_en[b], ew);
            chk(row_act[b] == ea, "R4", $sformatf("row_act[%0d]", b), row_act[b], ea);
        end
        chk(col_stb != 2'b11, "R11", "dual strobe", col_stb, 0);
        chk(rd_valid == exp_rdv, "R7", "rd_valid", rd_valid, exp_rdv);
        if (exp_rdv) chk(int'(rd_data) == exp_rd, "R7", "rd_data", rd_data, exp_rd);
        chk(int'(busy_cnt) == exp_busy, "R10", "busy_cnt", busy_cnt, exp_busy);
    endtask

    task automatic step();
        @(posedge clk);
        exp_rdv  = 0;
        accepted = 0;
        if (q.size() > 0) begin
            bit fin;
            exp_busy++;
            fin = (q.size() == 1);
            void'(q.pop_front());
            if (fin) begin
                last_valid = 1;
                last_wr    = m_wr;
                if (m_wr) mem[m_addr] = m_wdata;
                else begin
                    exp_rdv = 1;
                    exp_rd  = mem.exists(m_addr) ? mem[m_addr] : 0;
                end
            end
        end else if (req_valid) begin
            int r;
            bit hit, turn;
            accepted = 1;
            m_addr  = int'(req_addr);
            m_bank  = (m_addr >> 8) & 1;
            r       = (m_addr >> 4) & 15;
            m_wr    = req_wr;
            m_wdata = int'(req_wdata);
            hit  = open_v[m_bank] && (open_r[m_bank] == r);
            turn = last_valid && !last_wr && m_wr;
            if (!hit) begin
                q.push_back(0); q.push_back(0); q.push_back(0);
                open_v[m_bank] = 1;
                open_r[m_bank] = r;
            end
            if (turn) q.push_back(1);
            q.push_back(2); q.push_back(2);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic drain();
        while (q.size() > 0) step();
    endtask

    task automatic issue(logic [AW-1:0] a, bit w, int d);
        req_valid = 1; req_addr = a; req_wr = w; req_wdata = DW'(d);
        do step(); while (!accepted);
        req_valid = 0;
        drain();
    endtask

    // issues one request and checks its busy cost
    task automatic timed(logic [AW-1:0] a, bit w, int d, int cost, string req);
        int t0;
        t0 = int'(busy_cnt);
        issue(a, w, d);
        chk(int'(busy_cnt) - t0 == cost, req, "access cost", int'(busy_cnt) - t0, cost);
    endtask

    task automatic read_exp(logic [AW-1:0] a, int d, string req);
        int got;
        req_valid = 1; req_addr = a; req_wr = 0; req_wdata = '0;
        do step(); while (!accepted);
        req_valid = 0;
        while (q.size() > 0) step();
        got = int'(rd_data);
        chk(rd_valid && got == d, req, "read back", got, d);
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_addr = '0; req_wr = 0; req_wdata = '0;
        exp_busy = 0; exp_rdv = 0; last_valid = 0; last_wr = 0;
        open_v[0] = 0; open_v[1] = 0; open_r[0] = 0; open_r[1] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1", "ready", ready, 1);
        chk(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
        chk(row_act == 2'b00, "R1", "row_act", row_act, 0);
        chk(col_stb == 2'b00, "R1", "col_stb", col_stb, 0);
        chk(busy_cnt == 16'd0, "R1", "busy_cnt", busy_cnt, 0);
        rst_n = 1;
        step();

        timed(mk(0, 1, 3), 1, 'h1111, 5, "R4");          // closed row
        timed(mk(0, 1, 4), 1, 'h2222, 2, "R3");          // page hit
        timed(mk(0, 1, 3), 0, 0, 2, "R5");               // write->read: no turn
        chk(int'(rd_data) == 'h1111, "R7", "hit read data", rd_data, 'h1111);
        timed(mk(0, 1, 5), 1, 'h3333, 3, "R5");          // read->write: one turn
        timed(mk(1, 1, 3), 1, 'h4444, 5, "R2");          // other bank, same row/col
        chk(row_act == 2'b11, "R9", "both rows open", row_act, 3);
        timed(mk(0, 1, 3), 0, 0, 2, "R9");               // bank0 row still open
        chk(int'(rd_data) == 'h1111, "R2", "bank0 word", rd_data, 'h1111);
        read_exp(mk(1, 1, 3), 'h4444, "R2");

        // R6: a request offered and withdrawn while busy is ignored
        req_valid = 1; req_addr = mk(0, 2, 0); req_wr = 1; req_wdata = 'h5555;
        do step(); while (!accepted);
        req_addr = mk(0, 1, 4); req_wdata = 'h0BAD;
        step(); step(); step();
        req_valid = 0;
        drain();
        read_exp(mk(0, 1, 4), 'h2222, "R6");
        read_exp(mk(0, 2, 0), 'h5555, "R8");

        // R10: single-bank copy between two rows
        for (int c = 0; c < 4; c++) issue(mk(0, 3, c), 1, 'h100 + c);
        for (int c = 0; c < 4; c++) begin
            int t0;
            t0 = int'(busy_cnt);
            issue(mk(0, 3, c), 0, 0);
            issue(mk(0, 4, c), 1, 'h100 + c);
            if (c > 0) chk(int'(busy_cnt) - t0 == 11, "R10", "same-bank copy",
                           int'(busy_cnt) - t0, 11);
        end
        read_exp(mk(0, 4, 2), 'h102, "R8");

        // R10: copy across banks with both rows held open
        for (int c = 0; c < 4; c++) issue(mk(0, 5, c), 1, 'h200 + c);
        for (int c = 0; c < 4; c++) begin
            int t0;
            t0 = int'(busy_cnt);
            issue(mk(0, 5, c), 0, 0);
            issue(mk(1, 6, c), 1, 'h200 + c);
            if (c > 0) chk(int'(busy_cnt) - t0 == 5, "R10", "cross-bank copy",
                           int'(busy_cnt) - t0, 5);
        end
        chk(row_act == 2'b11, "R9", "rows held", row_act, 3);
        read_exp(mk(1, 6, 3), 'h203, "R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule